// File: doc/BRIEF.md
# Delayed Sync and Period Counter

This block produces three timing strobes for a downstream sync selector. Two of them are delayed copies of the external sync inputs `sync_a_in` and `sync_b_in`. Each copy passes through a fixed two-register path plus a programmable delay of 0 to 255 clocks. The third strobe is a one-clock terminal-count pulse from a free-running down-counter. The counter's period is always a whole multiple of 16 clocks.

Configuration uses a simple write port. Address 3 holds the two 8-bit delay values, and address 4 holds the 16-bit count value. The counter starts from the reload value of the default count and keeps running. A new count does not cut short the period already in progress. It takes effect at the next reload. Each delay path reproduces its input bit for bit, so back-to-back sync pulses stay distinct at the output.

Top module: `sync_timer`

## Requirements
- R1: `dsync_a` equals `sync_a_in` delayed by 2 + DA clocks, where DA is `wr_data[7:0]` of the last write to address 3.
- R2: `dsync_b` equals `sync_b_in` delayed by 2 + DB clocks, where DB is `wr_data[15:8]` of the last write to address 3.
- R3: The delay paths reproduce any input pattern exactly, including single-cycle and back-to-back pulses, for every delay from 0 to 255.
- R4: Reset clears both delay values to zero and forces `dsync_a`, `dsync_b` and `tc_pulse` low.
- R5: The counter reloads to 16*C+15, counts down by one per clock to zero and reloads again, so the period is 16*(C+1) clocks. C is `wr_data[15:0]` of a write to address 4.
- R6: `tc_pulse` is high for exactly one clock, the cycle in which the counter holds zero.
- R7: After reset C is 0x00FF and the counter holds 4095, so the first `tc_pulse` occurs 4095 clocks after the first non-reset edge. The period is 4096 clocks.
- R8: A count write changes only the next reload. A write in the cycle where the counter is zero applies to the reload after that.
- R9: Writes to addresses other than 3 and 4 change neither delay nor count, so no output timing changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| sync_a_in | input | 1 | External sync A |
| sync_b_in | input | 1 | External sync B |
| dsync_a | output | 1 | Delayed sync A |
| dsync_b | output | 1 | Delayed sync B |
| tc_pulse | output | 1 | Terminal-count pulse |

## Verification
On every cycle, the embedded assertions check the counter's step and reload arithmetic and the single-cycle width of the terminal-count pulse. They also check that each delay path with a zero setting tracks its input exactly two clocks later, and that the outputs are low after reset. Only the bench's scenarios can show the full programmable delay (long delays, back-to-back pulses, delay changes) and the deferred effect of a count write. These scenarios also cover the default period after reset and the rejection of writes to other addresses. The bench compares all of this against a behavioural model on every clock.

// File: rtl/sync_tmr_pkg.sv
package sync_tmr_pkg;
    localparam int DATA_W      = 16;
    localparam int ADDR_W      = 3;
    localparam int DLY_W       = 8;
    localparam int MAX_DLY     = (1 << DLY_W) - 1;
    localparam int CNT_W       = DATA_W;
    localparam int SUB_W       = 4;
    localparam int TMR_W       = CNT_W + SUB_W;
    localparam logic [ADDR_W-1:0] ADDR_DLY = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_CNT = 3'd4;
    localparam logic [CNT_W-1:0]  CNT_DEFAULT = 16'h00FF;

    typedef struct packed {
        logic [DLY_W-1:0] dly_b;
        logic [DLY_W-1:0] dly_a;
    } dly_cfg_t;

    typedef struct packed {
        logic             we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic [TMR_W-1:0] reload_of(input logic [CNT_W-1:0] c);
        return {c, {SUB_W{1'b1}}};
    endfunction
endpackage

// File: rtl/sync_tmr_regs.sv
module sync_tmr_regs
    import sync_tmr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  wr_req_t             req,
    output dly_cfg_t            dly_cfg,
    output logic [CNT_W-1:0]    count_cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dly_cfg   <= '0;
            count_cfg <= CNT_DEFAULT;
        end else if (req.we) begin
            if (req.addr == ADDR_DLY) dly_cfg   <= dly_cfg_t'(req.data);
            if (req.addr == ADDR_CNT) count_cfg <= req.data;
        end
    end
endmodule

// File: rtl/sync_delay_line.sv
module sync_delay_line #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sin,
    input  logic [DW-1:0] dly,
    output logic          dout
);
    localparam int DEPTH = 1 << DW;

    logic [DEPTH-1:0] taps_q;
    logic             out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            taps_q <= '0;
            out_q  <= 1'b0;
        end else begin
            taps_q <= {taps_q[DEPTH-2:0], sin};
            out_q  <= taps_q[dly];
        end
    end

    assign dout = out_q;

    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst) age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R1 / R2: with zero delay, the output is the input two clocks late
    a_r1_zero_delay: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3 && $past(dly) == '0) |-> dout == $past(sin, 2));
    // R4: outputs low straight after reset
    a_r4_reset_low: assert property (@(posedge clk) rst |=> !dout);
endmodule

// File: rtl/period_counter.sv
module period_counter
    import sync_tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count_cfg,
    output logic             tc
);
    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= reload_of(CNT_DEFAULT);
        else if (cnt_q == '0)  cnt_q <= reload_of(count_cfg);
        else                   cnt_q <= cnt_q - 1'b1;
    end

    assign tc = (cnt_q == '0);

    // R5: decrement by one between reloads
    a_r5_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
    // R5 / R8: reload uses the count value present in the zero cycle
    a_r5_reload: assert property (@(posedge clk) disable iff (rst)
        tc |=> cnt_q == {$past(count_cfg), 4'hF});
    // R6: the pulse never lasts longer than one clock
    a_r6_single: assert property (@(posedge clk) disable iff (rst)
        tc |=> !tc);
endmodule

// File: rtl/sync_timer.sv
module sync_timer
    import sync_tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [15:0]        wr_data,
    input  logic               sync_a_in,
    input  logic               sync_b_in,
    output logic               dsync_a,
    output logic               dsync_b,
    output logic               tc_pulse
);
    localparam int NCH = 2;

    wr_req_t          req;
    dly_cfg_t         dly_cfg;
    logic [CNT_W-1:0] count_cfg;
    logic [NCH-1:0]   sin_v;
    logic [NCH-1:0]   dout_v;
    logic [DLY_W-1:0] dly_v [NCH];

    assign req     = '{we: wr_en, addr: wr_addr, data: wr_data};
    assign sin_v   = {sync_b_in, sync_a_in};
    assign dly_v[0] = dly_cfg.dly_a;
    assign dly_v[1] = dly_cfg.dly_b;

    sync_tmr_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .dly_cfg   (dly_cfg),
        .count_cfg (count_cfg)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_dly
        sync_delay_line #(.DW(DLY_W)) u_line (
            .clk  (clk),
            .rst  (rst),
            .sin  (sin_v[g]),
            .dly  (dly_v[g]),
            .dout (dout_v[g])
        );
    end

    period_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .count_cfg (count_cfg),
        .tc        (tc_pulse)
    );

    assign dsync_a = dout_v[0];
    assign dsync_b = dout_v[1];

    // R9: writes to other addresses leave the configuration alone
    a_r9_other_addr: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != ADDR_DLY && wr_addr != ADDR_CNT)
            |=> ($stable(dly_cfg) && $stable(count_cfg)));
endmodule

// File: tb/test_sync_timer.sv
module test_sync_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        sa = 1'b0, sb = 1'b0;
    logic        dsa, dsb, tc;

    always #10 clk = ~clk;

    sync_timer i_sync_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sync_a_in(sa), .sync_b_in(sb),
        .dsync_a(dsa), .dsync_b(dsb), .tc_pulse(tc)
    );

    int n_run = 0, n_fail = 0, cyc = 0;
    string tag_a = "R4", tag_b = "R4", tag_t = "R4";
    logic [299:0] ha = '0, hb = '0;
    int md_a = 0, md_b = 0, mcount = 255, mcnt = 4095;
    logic ex_a = 0, ex_b = 0, ex_t = 0;
    bit   done = 0;

    // behavioural reference
    always @(posedge clk) begin
        if (rst) begin
            ha = '0; hb = '0; md_a = 0; md_b = 0; mcount = 255; mcnt = 4095;
            ex_a = 0; ex_b = 0; ex_t = 0;
        end else begin
            ha = {ha[298:0], sa};
            hb = {hb[298:0], sb};
            ex_a = ha[1 + md_a];
            ex_b = hb[1 + md_b];
            if (mcnt == 0) mcnt = 16 * mcount + 15;
            else mcnt = mcnt - 1;
            ex_t = (mcnt == 0);
            if (wr_en && wr_addr == 3'd3) begin
                md_a = int'(wr_data[7:0]);
                md_b = int'(wr_data[15:8]);
            end
            if (wr_en && wr_addr == 3'd4) mcount = int'(wr_data);
        end
    end

    task automatic check(string tag, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0b expected %0b", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!done) begin
            check(tag_a, dsa, ex_a);
            check(tag_b, dsb, ex_b);
            check(tag_t, tc, ex_t);
        end
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic write(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_random(int n, int density);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sa = ($urandom_range(99) < density);
            sb = ($urandom_range(99) < density);
        end
        @(negedge clk);
        sa = 0; sb = 0;
    endtask

    task automatic measure_period(string tag, int exp);
        int n = 0;
        while (tc !== 1'b1 && n < 70000) begin @(negedge clk); n++; end
        n = 0;
        @(negedge clk);
        while (tc !== 1'b1 && n < 70000) begin @(negedge clk); n++; end
        n_run++;
        if (n + 1 != exp) begin
            n_fail++;
            $display("FAIL %s period: actual %0d expected %0d", tag, n + 1, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R4: outputs low while in reset
        check("R4", dsa, 1'b0); check("R4", tc, 1'b0);
        rst = 1'b0;
        // R7: default period, zero delays
        tag_a = "R1"; tag_b = "R2"; tag_t = "R7";
        run_random(4200, 30);
        measure_period("R7", 4096);
        tag_t = "R6";
        // R1/R2: distinct delays
        write(3'd3, {8'd5, 8'd17});
        run_random(400, 40);
        // R3: maximum delay, single and back-to-back pulses
        tag_a = "R3"; tag_b = "R3";
        write(3'd3, 16'hFFFF);
        @(negedge clk); sa = 1; sb = 1;
        @(negedge clk); sa = 0; sb = 0;
        repeat (5) @(negedge clk);
        sa = 1; sb = 0;
        repeat (3) @(negedge clk);
        sa = 0; sb = 1;
        @(negedge clk); sb = 0;
        repeat (300) @(negedge clk);
        run_random(600, 60);
        write(3'd3, {8'd0, 8'd1});
        run_random(300, 80);
        // R9: other addresses ignored
        tag_a = "R9"; tag_b = "R9"; tag_t = "R9";
        write(3'd2, 16'h0000);
        write(3'd5, 16'h0000);
        write(3'd7, 16'h1234);
        run_random(600, 30);
        measure_period("R9", 4096);
        // R8: count write mid-period defers to next reload
        tag_a = "R1"; tag_b = "R2"; tag_t = "R8";
        write(3'd4, 16'd0);
        run_random(4300, 20);
        tag_t = "R5";
        measure_period("R5", 16);
        // R8: write landing in the zero cycle applies one reload later
        tag_t = "R8";
        while (tc !== 1'b1) @(negedge clk);
        wr_en = 1; wr_addr = 3'd4; wr_data = 16'd3;
        @(negedge clk); wr_en = 0;
        run_random(200, 20);
        measure_period("R8", 64);
        // R5: several counts
        tag_t = "R5";
        for (int k = 0; k < 4; k++) begin
            write(3'd4, 16'($urandom_range(6)));
            run_random(400, 25);
        end
        write(3'd4, 16'd1);
        run_random(100, 10);
        measure_period("R5", 32);
        // R4: reset mid-run
        @(negedge clk); rst = 1;
        @(negedge clk); tag_a = "R4"; tag_b = "R4"; tag_t = "R4";
        @(negedge clk); rst = 0;
        tag_t = "R7";
        run_random(300, 30);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule